// File: doc/BRIEF.md
# Extend and Subtract Execution Slice

This block is one integer execution slice of a 32-bit core that issues 16-bit instructions. Each cycle it may accept one instruction word with the two register values it names and the current condition flag T. The slice handles nine operations: sign or zero extension of the low byte or low halfword of the source register, plain negation, negation that also subtracts T, plain subtraction, subtraction that also subtracts T, and subtraction that reports signed overflow. Any other instruction word is reported as illegal.

All outputs are registered, so results appear exactly one clock after the instruction is accepted. A new instruction can be accepted every cycle. The result, its destination index, the new T value and two write strobes go back to the register file and flag logic around the slice. Both strobes stay low for an illegal word.

Top module: `exsub_unit`

## Requirements
- R1: Group nibble 0110 (bits 15:12) with function nibble 1110 (bits 3:0) yields the low byte of Rm sign-extended from bit 7. Function 1111 yields the low halfword sign-extended from bit 15.
- R2: Group 0110 with function 1100 yields the low byte of Rm with all upper bits cleared. Function 1101 does the same for the low halfword.
- R3: Group 0110 with function 1011 yields 0 minus Rm and leaves T unwritten.
- R4: Group 0110 with function 1010 yields 0 minus Rm minus T and writes the borrow out of bit 31 to T.
- R5: Group 0011 with function 1000 yields Rn minus Rm and leaves T unwritten.
- R6: Group 0011 with function 1010 yields Rn minus Rm minus T and writes the borrow to T.
- R7: Group 0011 with function 1011 yields Rn minus Rm. T is written and is set when Rn and Rm differ in sign and the result sign differs from Rn.
- R8: t_we is high only for the operations of R4, R6 and R7. When t_we is low, t_out repeats the t_in that came with the instruction.
- R9: Any other instruction word raises illegal for one cycle, with res_we and t_we low and res zero.
- R10: out_valid rises exactly one clock after each accepted instruction, back-to-back issue is supported, and no output appears without an accepted instruction.
- R11: rd_idx carries bits 11:8 of the instruction and rs_idx carries bits 7:4, delivered with the result.
- R12: While reset is high, out_valid, res_we, t_we, illegal and res are all zero on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 16 | Instruction word |
| rn_val | input | 32 | Value of destination/first operand register |
| rm_val | input | 32 | Value of source register |
| t_in | input | 1 | Current T flag |
| out_valid | output | 1 | Registered outcome valid |
| res | output | 32 | Result for Rn |
| res_we | output | 1 | Write result to Rn |
| rd_idx | output | 4 | Destination register index |
| rs_idx | output | 4 | Source register index |
| t_out | output | 1 | New T value |
| t_we | output | 1 | Write T |
| illegal | output | 1 | Instruction not recognised |

## Verification
On every cycle, the bound checker checks several things. It checks the one-cycle valid timing, that each valid outcome is either a write or an illegal report, and that illegal reports are quiet. It checks that a T write always comes with a result write and that T passes through unchanged when not written. It also checks the plain subtraction and byte sign-extension results and the destination index. The borrow and overflow values of the flag-writing subtracts and negates, the extension cases at the boundary bits, and the coverage of illegal words near legal encodings are shown only by the bench's scenarios, which compare them against an independent 64-bit reference model.

// File: rtl/exsub_pkg.sv
package exsub_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_SEXTB, OP_SEXTH, OP_ZEXTB, OP_ZEXTH,
    OP_NEG, OP_NEGB, OP_SUB, OP_SUBB, OP_SUBU
  } op_e;

  localparam logic [3:0] GRP_MOVX  = 4'b0110;
  localparam logic [3:0] GRP_ARITH = 4'b0011;

  localparam logic [3:0] FN_SEXTB = 4'b1110;
  localparam logic [3:0] FN_SEXTH = 4'b1111;
  localparam logic [3:0] FN_ZEXTB = 4'b1100;
  localparam logic [3:0] FN_ZEXTH = 4'b1101;
  localparam logic [3:0] FN_NEG   = 4'b1011;
  localparam logic [3:0] FN_NEGB  = 4'b1010;
  localparam logic [3:0] FN_SUB   = 4'b1000;
  localparam logic [3:0] FN_SUBB  = 4'b1010;
  localparam logic [3:0] FN_SUBU  = 4'b1011;

  function automatic logic op_writes_t(op_e op);
    return (op == OP_NEGB) || (op == OP_SUBB) || (op == OP_SUBU);
  endfunction

  function automatic logic op_is_negate(op_e op);
    return (op == OP_NEG) || (op == OP_NEGB);
  endfunction

  function automatic logic op_is_extend(op_e op);
    return (op == OP_SEXTB) || (op == OP_SEXTH) ||
           (op == OP_ZEXTB) || (op == OP_ZEXTH);
  endfunction
endpackage

// File: rtl/exsub_decode.sv
module exsub_decode
  import exsub_pkg::*;
#(
  parameter int ILEN = 16,
  parameter int RIDX = 4
) (
  input  logic [ILEN-1:0] opcode,
  output op_e             op,
  output logic            legal,
  output logic [RIDX-1:0] dst,
  output logic [RIDX-1:0] src
);
  localparam int GRP_LSB = ILEN - 4;
  localparam int DST_LSB = GRP_LSB - RIDX;
  localparam int SRC_LSB = DST_LSB - RIDX;

  logic [3:0] grp;
  logic [3:0] fn;

  assign grp = opcode[ILEN-1:GRP_LSB];
  assign fn  = opcode[3:0];
  assign dst = opcode[DST_LSB +: RIDX];
  assign src = opcode[SRC_LSB +: RIDX];

  always_comb begin
    op = OP_NONE;
    unique case (grp)
      GRP_MOVX: begin
        unique case (fn)
          FN_SEXTB: op = OP_SEXTB;
          FN_SEXTH: op = OP_SEXTH;
          FN_ZEXTB: op = OP_ZEXTB;
          FN_ZEXTH: op = OP_ZEXTH;
          FN_NEG:   op = OP_NEG;
          FN_NEGB:  op = OP_NEGB;
          default:  op = OP_NONE;
        endcase
      end
      GRP_ARITH: begin
        unique case (fn)
          FN_SUB:  op = OP_SUB;
          FN_SUBB: op = OP_SUBB;
          FN_SUBU: op = OP_SUBU;
          default: op = OP_NONE;
        endcase
      end
      default: op = OP_NONE;
    endcase
  end

  assign legal = (op != OP_NONE);
endmodule

// File: rtl/exsub_ext.sv
module exsub_ext #(
  parameter int XLEN   = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] src,
  input  logic              wide,
  input  logic              signed_mode,
  output logic [XLEN-1:0]   y
);
  localparam int BYTE_PAD = XLEN - BYTE_W;
  localparam int HALF_PAD = XLEN - HALF_W;

  logic [XLEN-1:0] y_byte;
  logic [XLEN-1:0] y_half;
  logic            fill_b;
  logic            fill_h;

  assign fill_b = signed_mode & src[BYTE_W-1];
  assign fill_h = signed_mode & src[HALF_W-1];
  assign y_byte = {{BYTE_PAD{fill_b}}, src[BYTE_W-1:0]};
  assign y_half = {{HALF_PAD{fill_h}}, src};
  assign y      = wide ? y_half : y_byte;
endmodule

// File: rtl/exsub_sub.sv
module exsub_sub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  output logic [XLEN-1:0] diff,
  output logic            borrow,
  output logic            vflow
);
  logic [XLEN:0] wide_diff;

  assign wide_diff = {1'b0, a} - {1'b0, b} - {{XLEN{1'b0}}, cin};
  assign diff      = wide_diff[XLEN-1:0];
  assign borrow    = wide_diff[XLEN];
  assign vflow     = (a[XLEN-1] ^ b[XLEN-1]) & (diff[XLEN-1] ^ a[XLEN-1]);
endmodule

// File: rtl/exsub_unit.sv
module exsub_unit
  import exsub_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ILEN   = 16,
  parameter int RIDX   = 4,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [ILEN-1:0] opcode,
  input  logic [XLEN-1:0] rn_val,
  input  logic [XLEN-1:0] rm_val,
  input  logic            t_in,
  output logic            out_valid,
  output logic [XLEN-1:0] res,
  output logic            res_we,
  output logic [RIDX-1:0] rd_idx,
  output logic [RIDX-1:0] rs_idx,
  output logic            t_out,
  output logic            t_we,
  output logic            illegal
);
  op_e             op;
  logic            legal;
  logic [RIDX-1:0] dst, src;

  exsub_decode #(.ILEN(ILEN), .RIDX(RIDX)) u_dec (
    .opcode(opcode), .op(op), .legal(legal), .dst(dst), .src(src)
  );

  logic [XLEN-1:0] ext_y;
  logic            ext_wide, ext_signed;

  assign ext_wide   = (op == OP_SEXTH) || (op == OP_ZEXTH);
  assign ext_signed = (op == OP_SEXTB) || (op == OP_SEXTH);

  exsub_ext #(.XLEN(XLEN), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_ext (
    .src(rm_val[HALF_W-1:0]), .wide(ext_wide), .signed_mode(ext_signed),
    .y(ext_y)
  );

  logic [XLEN-1:0] sub_a, sub_y;
  logic            sub_cin, sub_borrow, sub_vflow;

  assign sub_a   = op_is_negate(op) ? '0 : rn_val;
  assign sub_cin = ((op == OP_NEGB) || (op == OP_SUBB)) ? t_in : 1'b0;

  exsub_sub #(.XLEN(XLEN)) u_sub (
    .a(sub_a), .b(rm_val), .cin(sub_cin),
    .diff(sub_y), .borrow(sub_borrow), .vflow(sub_vflow)
  );

  logic [XLEN-1:0] res_d;
  logic            t_d, twe_d;

  always_comb begin
    res_d = '0;
    if (legal) res_d = op_is_extend(op) ? ext_y : sub_y;
    twe_d = legal && op_writes_t(op);
    t_d   = t_in;
    if (op == OP_SUBU)                         t_d = sub_vflow;
    else if (op == OP_NEGB || op == OP_SUBB)   t_d = sub_borrow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res       <= '0;
      res_we    <= 1'b0;
      rd_idx    <= '0;
      rs_idx    <= '0;
      t_out     <= 1'b0;
      t_we      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      res       <= in_valid ? res_d : '0;
      res_we    <= in_valid && legal;
      rd_idx    <= dst;
      rs_idx    <= src;
      t_out     <= t_d;
      t_we      <= in_valid && twe_d;
      illegal   <= in_valid && !legal;
    end
  end
endmodule

// File: rtl/exsub_unit_chk.sv
module exsub_unit_chk #(
  parameter int XLEN   = 32,
  parameter int ILEN   = 16,
  parameter int RIDX   = 4,
  parameter int BYTE_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [ILEN-1:0] opcode,
  input logic [XLEN-1:0] rn_val,
  input logic [XLEN-1:0] rm_val,
  input logic            t_in,
  input logic            out_valid,
  input logic [XLEN-1:0] res,
  input logic            res_we,
  input logic [RIDX-1:0] rd_idx,
  input logic            t_out,
  input logic            t_we,
  input logic            illegal
);
  logic is_sub, is_sextb;
  assign is_sub   = (opcode[ILEN-1 -: 4] == 4'b0011) && (opcode[3:0] == 4'b1000);
  assign is_sextb = (opcode[ILEN-1 -: 4] == 4'b0110) && (opcode[3:0] == 4'b1110);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!res_we && !t_we && res == '0));
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({res_we, illegal}) == 1));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!res_we && !t_we && !illegal));
  a_r8_twe_needs_we: assert property (@(posedge clk) disable iff (rst)
    t_we |-> res_we);
  a_r8_t_passthru: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (t_we || t_out == $past(t_in)));
  a_r5_sub_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sub) |=> (res == $past(rn_val) - $past(rm_val) && !t_we));
  a_r1_sext_byte: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sextb) |=>
      (res == {{(XLEN-BYTE_W){$past(rm_val[BYTE_W-1])}}, $past(rm_val[BYTE_W-1:0])}));
  a_r11_dst_index: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (rd_idx == $past(opcode[ILEN-5 -: RIDX])));
endmodule

bind exsub_unit exsub_unit_chk #(
  .XLEN(XLEN), .ILEN(ILEN), .RIDX(RIDX), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
  .rn_val(rn_val), .rm_val(rm_val), .t_in(t_in), .out_valid(out_valid),
  .res(res), .res_we(res_we), .rd_idx(rd_idx), .t_out(t_out),
  .t_we(t_we), .illegal(illegal)
);

// File: tb/exsub_unit_test.sv
module exsub_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic [31:0] rn_val = '0;
  logic [31:0] rm_val = '0;
  logic        t_in = 1'b0;
  logic        out_valid, res_we, t_out, t_we, illegal;
  logic [31:0] res;
  logic [3:0]  rd_idx, rs_idx;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exsub_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .rn_val(rn_val), .rm_val(rm_val), .t_in(t_in), .out_valid(out_valid),
    .res(res), .res_we(res_we), .rd_idx(rd_idx), .rs_idx(rs_idx),
    .t_out(t_out), .t_we(t_we), .illegal(illegal)
  );

  typedef struct {
    logic [31:0] res;
    bit          we;
    bit          t;
    bit          twe;
    bit          ill;
    logic [3:0]  rd;
    logic [3:0]  rs;
    string       rq;
  } exp_t;

  exp_t sb[$];

  function automatic exp_t model(logic [15:0] op, logic [31:0] rn,
                                 logic [31:0] rm, bit t, string rq);
    exp_t e;
    longint d;
    longint s;
    e.rq = rq; e.rd = op[11:8]; e.rs = op[7:4];
    e.res = 0; e.we = 1; e.t = t; e.twe = 0; e.ill = 0;
    if (op[15:12] == 4'h6 && op[3:0] == 4'hE)
      e.res = 32'(int'($signed(rm[7:0])));
    else if (op[15:12] == 4'h6 && op[3:0] == 4'hF)
      e.res = 32'(int'($signed(rm[15:0])));
    else if (op[15:12] == 4'h6 && op[3:0] == 4'hC)
      e.res = 32'(rm[7:0]);
    else if (op[15:12] == 4'h6 && op[3:0] == 4'hD)
      e.res = 32'(rm[15:0]);
    else if (op[15:12] == 4'h6 && op[3:0] == 4'hB)
      e.res = 32'(64'd0 - 64'(rm));
    else if (op[15:12] == 4'h6 && op[3:0] == 4'hA) begin
      d = 64'd0 - longint'({32'd0, rm}) - longint'(t);
      e.res = d[31:0]; e.t = (d < 0); e.twe = 1;
    end else if (op[15:12] == 4'h3 && op[3:0] == 4'h8)
      e.res = rn - rm;
    else if (op[15:12] == 4'h3 && op[3:0] == 4'hA) begin
      d = longint'({32'd0, rn}) - longint'({32'd0, rm}) - longint'(t);
      e.res = d[31:0]; e.t = (d < 0); e.twe = 1;
    end else if (op[15:12] == 4'h3 && op[3:0] == 4'hB) begin
      s = longint'($signed(rn)) - longint'($signed(rm));
      e.res = s[31:0];
      e.t = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      e.twe = 1;
    end else begin
      e.we = 0; e.ill = 1;
    end
    return e;
  endfunction

  task automatic fail_line(string rq, string what, logic [31:0] act, logic [31:0] exp);
    failures++;
    $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
  endtask

  task automatic issue(logic [15:0] op, logic [31:0] rn, logic [31:0] rm,
                       bit t, string rq);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; rn_val = rn; rm_val = rm; t_in = t;
    sb.push_back(model(op, rn, rm, t, rq));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor: compares each outcome against the oldest expected item.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fail_line("R10", "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        if (res !== e.res)       fail_line(e.rq, "res", res, e.res);
        if (res_we !== e.we)     fail_line(e.rq, "res_we", 32'(res_we), 32'(e.we));
        if (t_we !== e.twe)      fail_line(e.twe ? e.rq : "R8", "t_we", 32'(t_we), 32'(e.twe));
        if (t_out !== e.t)       fail_line(e.twe ? e.rq : "R8", "t_out", 32'(t_out), 32'(e.t));
        if (illegal !== e.ill)   fail_line(e.ill ? "R9" : e.rq, "illegal", 32'(illegal), 32'(e.ill));
        if (rd_idx !== e.rd)     fail_line("R11", "rd_idx", 32'(rd_idx), 32'(e.rd));
        if (rs_idx !== e.rs)     fail_line("R11", "rs_idx", 32'(rs_idx), 32'(e.rs));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R12: reset with an instruction presented must keep all outputs quiet.
    in_valid = 1'b1; opcode = 16'h3018; rn_val = 32'd9; rm_val = 32'd2;
    repeat (3) begin
      @(negedge clk);
      checks++;
      if ({out_valid, res_we, t_we, illegal} !== 4'b0 || res !== 32'd0)
        fail_line("R12", "reset outputs", {27'd0, out_valid, res_we, t_we, illegal, |res}, 32'd0);
    end
    in_valid = 1'b0;
    rst = 1'b0;

    // R1 sign extension, byte and halfword, both signs
    issue(16'h612E, 32'hDEAD_BEEF, 32'h1234_56F0, 0, "R1");
    issue(16'h6A3E, 32'h0, 32'hFFFF_FF7F, 1, "R1");
    issue(16'h645F, 32'h0, 32'h0000_8001, 0, "R1");
    issue(16'h6F0F, 32'h0, 32'hABCD_7FFF, 1, "R1");
    // R2 zero extension
    issue(16'h621C, 32'h0, 32'hFFFF_FF80, 1, "R2");
    issue(16'h623D, 32'h0, 32'hFFFF_8001, 0, "R2");
    idle();
    // R3 negate, T untouched
    issue(16'h654B, 32'h0, 32'h0000_0001, 1, "R3");
    issue(16'h654B, 32'h0, 32'h0000_0000, 0, "R3");
    issue(16'h6E1B, 32'h0, 32'h8000_0000, 1, "R3");
    // R4 negate with borrow
    issue(16'h601A, 32'h0, 32'h0000_0000, 0, "R4");
    issue(16'h601A, 32'h0, 32'h0000_0000, 1, "R4");
    issue(16'h672A, 32'h0, 32'h0000_0005, 0, "R4");
    issue(16'h672A, 32'h0, 32'h8000_0000, 1, "R4");
    // R5 subtract
    issue(16'h3128, 32'd5, 32'd7, 1, "R5");
    issue(16'h3BC8, 32'h8000_0000, 32'd1, 0, "R5");
    // R6 subtract with borrow
    issue(16'h312A, 32'd5, 32'd5, 1, "R6");
    issue(16'h312A, 32'd10, 32'd3, 1, "R6");
    issue(16'h345A, 32'd0, 32'hFFFF_FFFF, 1, "R6");
    issue(16'h345A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R6");
    idle();
    idle();
    // R7 subtract with overflow report
    issue(16'h3DEB, 32'h8000_0000, 32'd1, 0, "R7");
    issue(16'h3DEB, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, "R7");
    issue(16'h3DEB, 32'd5, 32'd3, 1, "R7");
    issue(16'h3DEB, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1, "R7");
    // R9 illegal words, including near neighbours of legal encodings
    issue(16'h0000, 32'd1, 32'd2, 1, "R9");
    issue(16'h6009, 32'd1, 32'd2, 0, "R9");
    issue(16'h3009, 32'd1, 32'd2, 1, "R9");
    issue(16'h3001, 32'd1, 32'd2, 0, "R9");
    issue(16'hF00E, 32'd1, 32'd2, 1, "R9");
    issue(16'h700E, 32'd1, 32'd2, 0, "R9");
    // mix legal and illegal back to back for R10
    issue(16'h3128, 32'd100, 32'd1, 0, "R10");
    issue(16'h2128, 32'd100, 32'd1, 0, "R10");
    issue(16'h6FFE, 32'd0, 32'h0000_0080, 1, "R10");
    idle();
    repeat (3) @(negedge clk);

    // R10: every accepted instruction produced exactly one outcome
    checks++;
    if (sb.size() != 0) fail_line("R10", "pending outcomes", 32'(sb.size()), 32'd0);
    checks++;
    if (out_valid !== 1'b0) fail_line("R10", "out_valid after idle", 32'(out_valid), 32'd0);
    finish_run();
  end
endmodule